// File: doc/BRIEF.md
# Flash Sector Erase Command Sequencer

This block is the command front end of one NOR-style flash bank, restricted to sector erase. It watches single-cycle write strobes carrying an address and a data byte, and it recognises a six-write erase command. The last write of that command names the first sector. A timed acceptance window then opens. Each further sector-add write inside the window queues another sector and restarts the window. When the window runs out with no new write, the erase phase begins.

During the erase phase the block reports busy, shows which sectors are being erased, and accepts only a suspend write. A suspended erase keeps its remaining time and continues when a resume write arrives. The array erase itself is modelled as a down-counter of programmable length. When that counter runs out, the bank returns to array read with an empty sector map.

Top module: `erase_cmd_seq`

## Requirements
- R1: After a synchronous reset the outputs are idle: ready=1, erase_active=0, suspended=0, tmr_expired=0, sector_sel=0.
- R2: The start command is six strobed writes, matched on wr_addr[11:0]: 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address with data 30h. The sector index is wr_addr[15:13] (the top SECT_W bits). On the clock after the sixth write, ready=0, tmr_expired=0 and that sector's bit is set.
- R3: A write that does not match the expected step of the six-write command returns the sequencer to idle and leaves every output unchanged. A later complete command still works.
- R4: With no write, the window lasts exactly WIN_CYC cycles. After that, tmr_expired=1 and erase_active=1 while ready stays 0.
- R5: Inside the window, a 30h write sets the addressed sector's bit and restarts the full window. Sectors may be added in any order, and re-adding a sector that is already set is harmless.
- R6: Inside the window, F0h or any data byte other than 30h/B0h clears sector_sel, sets ready=1 and starts no erase.
- R7: Inside the window, a B0h write changes nothing and does not restart the window.
- R8: The erase phase lasts ERASE_CYC cycles of running time. At its end, sector_sel clears, ready=1, and erase_active=0 and tmr_expired=0.
- R9: While erasing, every write other than B0h is ignored, including 30h, F0h and unlock writes.
- R10: A B0h write while erasing sets suspended=1, ready=1 and erase_active=0, keeps tmr_expired=1, and freezes the remaining time. A 30h write resumes the erase with that remaining time. Other writes while suspended are ignored.
- R11: If a B0h write falls in the last erase cycle, completion wins. If a 30h write falls in the last window cycle, the sector is added and the window restarts.
- R12: A reset asserted during the erase phase ends it on the next clock and returns all outputs to their idle values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe marking a bus write (end of write pulse) |
| wr_addr | input | ADDR_W | Write address; low 12 bits match unlock addresses, top SECT_W bits select the sector |
| wr_data | input | 8 | Write data byte (command code) |
| sector_sel | output | NUM_SECT | Bitmap of sectors queued for, or under, erase |
| erase_active | output | 1 | Erase phase running (not suspended) |
| ready | output | 1 | 1 = ready, 0 = busy (window open or erase running) |
| tmr_expired | output | 1 | 0 while the window is open, 1 once erase has begun (also while suspended) |
| suspended | output | 1 | Erase suspended |

## Verification
Two collisions can happen in the same clock.

- **Sector add at window expiry:** a 30h write can land in the final cycle of the acceptance window. The bench waits until its model shows zero window cycles left, then issues the write on exactly that edge. It expects the sector to be added and a full new window to start, not the erase.
- **Suspend at erase completion:** a B0h write can land in the final erase cycle. The bench aligns it in the same way and expects completion to win, so it must see ready=1 and suspended=0.

A behavioural model in the bench is compared with every output on every clock. A wrong priority in either case therefore appears as a miscompare in the cycle that follows.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam int MATCH_W = 12;
  localparam logic [MATCH_W-1:0] ADR_A = 12'h555;
  localparam logic [MATCH_W-1:0] ADR_B = 12'h2AA;
  localparam logic [7:0] CODE_KEY1  = 8'hAA;
  localparam logic [7:0] CODE_KEY2  = 8'h55;
  localparam logic [7:0] CODE_SETUP = 8'h80;
  localparam logic [7:0] CODE_ADD   = 8'h30;
  localparam logic [7:0] CODE_HOLD  = 8'hB0;
  localparam logic [7:0] CODE_ABORT = 8'hF0;

  typedef enum logic [3:0] {
    S_IDLE, S_K1, S_K2, S_SETUP, S_K3, S_K4, S_WIN, S_ERASE, S_SUSP
  } seq_state_e;

  typedef struct packed {
    logic key1;   // 555h / AAh
    logic key2;   // 2AAh / 55h
    logic setup;  // 555h / 80h
    logic add;    // 30h, any address
    logic hold;   // B0h
    logic abort;  // F0h
  } cmd_hit_t;
endpackage

// File: rtl/cmd_match.sv
module cmd_match
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output cmd_hit_t          hit
);
  logic [MATCH_W-1:0] lo;
  assign lo = addr[MATCH_W-1:0];

  always_comb begin
    hit.key1  = (lo == ADR_A) && (data == CODE_KEY1);
    hit.key2  = (lo == ADR_B) && (data == CODE_KEY2);
    hit.setup = (lo == ADR_A) && (data == CODE_SETUP);
    hit.add   = (data == CODE_ADD);
    hit.hold  = (data == CODE_HOLD);
    hit.abort = (data == CODE_ABORT);
  end
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                     cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R4/R8: a running count only moves down by one
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R10: a held count does not move
  a_r10_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(cnt_q));
endmodule

// File: rtl/sector_buf.sv
module sector_buf #(
  parameter int NUM_SECT = 8,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set,
  input  logic [SECT_W-1:0]   idx,
  input  logic                clr,
  output logic [NUM_SECT-1:0] sel
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)                       sel[i] <= 1'b0;
      else if (set && idx == SECT_W'(i))    sel[i] <= 1'b1;
    end
  end

  // R5: an added sector is selected on the next clock
  a_r5_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> sel[$past(idx)]);
  // R5: adding never drops another sector
  a_r5_no_loss: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((sel & $past(sel)) == $past(sel)));
endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_SECT  = 8,
  parameter int WIN_CYC   = 2500,
  parameter int ERASE_CYC = 5000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic [NUM_SECT-1:0] sector_sel,
  output logic                erase_active,
  output logic                ready,
  output logic                tmr_expired,
  output logic                suspended
);
  localparam int SECT_W = $clog2(NUM_SECT);
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam int ERS_W  = $clog2(ERASE_CYC + 1);

  seq_state_e st_q, st_d;
  cmd_hit_t   hit;
  logic win_load, win_run, win_zero;
  logic ers_load, ers_run, ers_zero;
  logic buf_set, buf_clr;
  logic [SECT_W-1:0] sect_idx;

  assign sect_idx = wr_addr[ADDR_W-1 -: SECT_W];

  cmd_match #(.ADDR_W(ADDR_W)) u_match (
    .addr(wr_addr), .data(wr_data), .hit(hit)
  );

  cycle_timer #(.CNT_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .load(win_load),
    .load_val(WIN_W'(WIN_CYC - 1)), .run(win_run), .zero(win_zero)
  );

  cycle_timer #(.CNT_W(ERS_W)) u_ers (
    .clk(clk), .rst(rst), .load(ers_load),
    .load_val(ERS_W'(ERASE_CYC - 1)), .run(ers_run), .zero(ers_zero)
  );

  sector_buf #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_buf (
    .clk(clk), .rst(rst), .set(buf_set), .idx(sect_idx),
    .clr(buf_clr), .sel(sector_sel)
  );

  always_comb begin
    st_d     = st_q;
    win_load = 1'b0;
    win_run  = 1'b0;
    ers_load = 1'b0;
    ers_run  = 1'b0;
    buf_set  = 1'b0;
    buf_clr  = 1'b0;
    unique case (st_q)
      S_IDLE:  if (wr_stb && hit.key1) st_d = S_K1;
      S_K1:    if (wr_stb) st_d = hit.key2  ? S_K2    : S_IDLE;
      S_K2:    if (wr_stb) st_d = hit.setup ? S_SETUP : S_IDLE;
      S_SETUP: if (wr_stb) st_d = hit.key1  ? S_K3    : S_IDLE;
      S_K3:    if (wr_stb) st_d = hit.key2  ? S_K4    : S_IDLE;
      S_K4: begin
        if (wr_stb) begin
          if (hit.add) begin
            st_d     = S_WIN;
            buf_set  = 1'b1;
            win_load = 1'b1;
          end else begin
            st_d = S_IDLE;
          end
        end
      end
      S_WIN: begin
        win_run = 1'b1;
        if (wr_stb && hit.add) begin
          buf_set  = 1'b1;
          win_load = 1'b1;
        end else if (wr_stb && !hit.hold) begin
          buf_clr = 1'b1;
          st_d    = S_IDLE;
        end else if (win_zero) begin
          st_d     = S_ERASE;
          ers_load = 1'b1;
        end
      end
      S_ERASE: begin
        if (ers_zero) begin
          buf_clr = 1'b1;
          st_d    = S_IDLE;
        end else if (wr_stb && hit.hold) begin
          st_d = S_SUSP;
        end else begin
          ers_run = 1'b1;
        end
      end
      S_SUSP:  if (wr_stb && hit.add) st_d = S_ERASE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= S_IDLE;
      ready        <= 1'b1;
      erase_active <= 1'b0;
      tmr_expired  <= 1'b0;
      suspended    <= 1'b0;
    end else begin
      st_q         <= st_d;
      ready        <= !(st_d == S_WIN || st_d == S_ERASE);
      erase_active <= (st_d == S_ERASE);
      tmr_expired  <= (st_d == S_ERASE || st_d == S_SUSP);
      suspended    <= (st_d == S_SUSP);
    end
  end

  // R4: busy without expiry means the window is open, not erasing
  a_r4_window_flag: assert property (@(posedge clk) disable iff (rst)
    (!ready && !erase_active) |-> !tmr_expired);
  // R8: busy, erasing or suspended implies at least one sector queued
  a_r8_sel_nonempty: assert property (@(posedge clk) disable iff (rst)
    (!ready || erase_active || suspended) |-> (sector_sel != '0));
  // R10: suspended reports ready and expired, never active
  a_r10_susp_flags: assert property (@(posedge clk) disable iff (rst)
    suspended |-> (ready && tmr_expired && !erase_active));
  // R9: the sector map does not change during erase except the final clear
  a_r9_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    erase_active |=> ($stable(sector_sel) || sector_sel == '0));
  // R6: an illegal code inside the window aborts to idle
  a_r6_abort: assert property (@(posedge clk) disable iff (rst)
    (!ready && !tmr_expired && wr_stb && wr_data != CODE_ADD && wr_data != CODE_HOLD)
    |=> (ready && sector_sel == '0 && !tmr_expired));
endmodule

// File: tb/sim_erase_cmd_seq.sv
`timescale 1ns/1ps
module sim_erase_cmd_seq;
  localparam int ADDR_W = 16, NUM_SECT = 8, SECT_W = 3;
  localparam int WIN = 20, ERS = 40;

  logic clk = 1'b0, rst = 1'b1, wr_stb = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NUM_SECT-1:0] sector_sel;
  logic erase_active, ready, tmr_expired, suspended;

  erase_cmd_seq #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .WIN_CYC(WIN), .ERASE_CYC(ERS)) u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sector_sel(sector_sel), .erase_active(erase_active), .ready(ready),
    .tmr_expired(tmr_expired), .suspended(suspended));

  always #10 clk = ~clk;  // 50 MHz

  // behavioural model: 0 idle, 1..5 writes matched, 6 window, 7 erasing, 8 suspended
  int m_mode = 0, m_wleft = 0, m_eleft = 0;
  bit [NUM_SECT-1:0] m_sel = '0;
  int vectors = 0, miscompares = 0, cyc = 0;
  bit cmp_en = 0, finished = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    automatic bit lo555 = (wr_addr[11:0] == 12'h555);
    automatic bit lo2aa = (wr_addr[11:0] == 12'h2AA);
    automatic int idx = int'(wr_addr[ADDR_W-1 -: SECT_W]);
    cyc++;
    if (rst) begin
      m_mode = 0; m_sel = '0; m_wleft = 0; m_eleft = 0;
    end else begin
      case (m_mode)
        0: if (wr_stb && lo555 && wr_data == 8'hAA) m_mode = 1;
        1: if (wr_stb) m_mode = (lo2aa && wr_data == 8'h55) ? 2 : 0;
        2: if (wr_stb) m_mode = (lo555 && wr_data == 8'h80) ? 3 : 0;
        3: if (wr_stb) m_mode = (lo555 && wr_data == 8'hAA) ? 4 : 0;
        4: if (wr_stb) m_mode = (lo2aa && wr_data == 8'h55) ? 5 : 0;
        5: if (wr_stb) begin
             if (wr_data == 8'h30) begin m_sel[idx] = 1'b1; m_mode = 6; m_wleft = WIN - 1; end
             else m_mode = 0;
           end
        6: if (wr_stb && wr_data == 8'h30) begin m_sel[idx] = 1'b1; m_wleft = WIN - 1; end
           else if (wr_stb && wr_data != 8'hB0) begin m_sel = '0; m_mode = 0; end
           else if (m_wleft == 0) begin m_mode = 7; m_eleft = ERS - 1; end
           else m_wleft--;
        7: if (m_eleft == 0) begin m_mode = 0; m_sel = '0; end
           else if (wr_stb && wr_data == 8'hB0) m_mode = 8;
           else m_eleft--;
        8: if (wr_stb && wr_data == 8'h30) m_mode = 7;
        default: m_mode = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      automatic logic [NUM_SECT+3:0] act = {ready, erase_active, suspended, tmr_expired, sector_sel};
      automatic logic [NUM_SECT+3:0] exp = {!(m_mode == 6 || m_mode == 7), m_mode == 7,
                                            m_mode == 8, m_mode == 7 || m_mode == 8, m_sel};
      vectors++;
      if (act !== exp) begin
        miscompares++;
        $display("FAIL %s cycle %0d: {rdy,act,sus,exp,sel} actual=%b expected=%b", cur_req, cyc, act, exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] sa(input int s);
    return ADDR_W'(s) << (ADDR_W - SECT_W);
  endfunction

  task automatic start_seq(input int s);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(sa(s), 8'h30);
  endtask

  task automatic wait_mode(input int m);
    while (m_mode != m) @(negedge clk);
  endtask

  initial begin
    idle(3);
    cmp_en = 1;
    @(negedge clk); rst = 1'b0;   // R1: outputs compared while and after reset
    idle(2);

    cur_req = "R2"; start_seq(3);
    cur_req = "R4"; wait_mode(7);
    cur_req = "R8"; wait_mode(0); idle(3);

    cur_req = "R3";  // mismatch at each step, including the sector step
    wr(16'h0555, 8'hAB); idle(2);
    wr(16'h0555, 8'hAA); wr(16'h0555, 8'h55); idle(2);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h02AA, 8'h80); idle(2);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80); wr(16'h0555, 8'hA0); idle(2);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02A0, 8'h55); idle(2);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(sa(5), 8'h31); idle(4);

    cur_req = "R5"; start_seq(1); idle(5); wr(sa(6), 8'h30); idle(12);
    wr(sa(0), 8'h30); idle(3); wr(sa(6), 8'h30);
    cur_req = "R7"; idle(4); wr(sa(2), 8'hB0);
    cur_req = "R9"; wait_mode(7); idle(3);
    wr(sa(4), 8'h30); wr(16'h0555, 8'hF0); wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
    cur_req = "R10"; wr(16'h0000, 8'hB0); idle(15);
    wr(16'h0000, 8'hF0); wr(16'h0555, 8'hAA); idle(4);
    wr(16'h0000, 8'h30);
    cur_req = "R8"; wait_mode(0); idle(3);

    cur_req = "R6"; start_seq(2); wr(sa(4), 8'h30); wr(sa(4), 8'h40); idle(5);
    start_seq(7); idle(3); wr(16'h0000, 8'hF0); idle(5);

    cur_req = "R11"; start_seq(0);
    while (!(m_mode == 6 && m_wleft == 0)) @(negedge clk);
    wr_stb = 1'b1; wr_addr = sa(5); wr_data = 8'h30; @(negedge clk); wr_stb = 1'b0;
    wait_mode(7);
    while (!(m_mode == 7 && m_eleft == 0)) @(negedge clk);
    wr_stb = 1'b1; wr_addr = '0; wr_data = 8'hB0; @(negedge clk); wr_stb = 1'b0;
    idle(4);

    cur_req = "R12"; start_seq(6); wait_mode(7); idle(7);
    rst = 1'b1; @(negedge clk); rst = 1'b0; idle(4);
    cur_req = "R2"; start_seq(1); wait_mode(0); idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule